// File: doc/BRIEF.md
# Masked Time-of-Day Alarm with Interrupt Router

This block watches the current minutes, hours and day-of-week fields of a calendar clock and raises a time-of-day alarm when they agree with three programmed alarm registers. It only looks at them when the clock signals that the seconds have rolled over. Each alarm register has a "don't care" bit in bit 7. These bits let the alarm fire once a week, once a day, once an hour or on every minute.

The block also holds the command register. That register decides the following:
- whether each alarm may reach a pin;
- whether the interrupts are level or fixed-length pulses;
- which of the two interrupt outputs carries the time-of-day alarm and which carries the watchdog request from a neighbouring timer.

Software reads and writes all of this over a simple one-cycle register strobe. Touching an alarm register acknowledges the time-of-day alarm. Touching either watchdog-time address acknowledges the watchdog alarm.

Top module: `tod_alarm_irq`

## Requirements
- R1: After reset the command register (address 0xB) reads 0xC0, the alarm registers read 0x00, and both interrupt outputs are low.
- R2: The alarm registers sit at minutes 0x3, hours 0x5 and day 0x7, with bit 7 as the don't-care bit. They read back what was written, except that bits 6..3 of the day register always read 0.
- R3: With no don't-care bit set, a rollover strobe sets the alarm flag (command bit 0) only when minutes, hours and day all equal the alarm values.
- R4: With only the day don't-care bit set, a rollover strobe sets the flag when hours and minutes match, whatever the day.
- R5: With the day and hour don't-care bits set, a rollover strobe sets the flag when the minutes match.
- R6: With all three don't-care bits set, every rollover strobe sets the flag.
- R7: Matching time fields without a rollover strobe never set the flag.
- R8: A read or write to 0x3, 0x5 or 0x7 clears the alarm flag and its interrupt. It also wins over a match arriving in the same cycle.
- R9: Command bits 1 (watchdog flag) and 0 (alarm flag) are read-only, and writes to them have no effect.
- R10: Command bit 2 set keeps the alarm off its pin, and command bit 3 set keeps the watchdog off its pin. The flags still set.
- R11: With command bit 6 at 1, `irq_a` carries the alarm and `irq_b` the watchdog. At 0 they are swapped. Each output follows its flag one cycle later.
- R12: With command bit 4 at 1 each flag, and its interrupt, stays high for exactly PULSE_CYC cycles and then clears itself. At 0 a flag holds until acknowledged.
- R13: A `wd_req` pulse sets the watchdog flag (command bit 1). Any read or write to 0xC or 0xD clears it, and those addresses read 0 here.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | One-cycle register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Register address |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered, valid the cycle after a read |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD, bit 7 zero |
| cur_day | input | 8 | Current day of week, BCD |
| sec_roll | input | 1 | Seconds rolled over; the time fields already carry the new minute |
| wd_req | input | 1 | Watchdog expiry event |
| irq_a | output | 1 | Interrupt output A, active high |
| irq_b | output | 1 | Interrupt output B, active high |

## Verification
The bench builds the block with PULSE_CYC set to 5 rather than the default of 3000. This makes the end of a pulse, the self-clearing of its flag and the interaction with a later read all land within a few cycles. It can therefore compare every cycle of a pulse against the reference model. The address map is fixed in the package, so each mask pattern, route setting and clear-versus-set collision is reached through ordinary bus traffic.

// File: rtl/tod_irq_pkg.sv
package tod_irq_pkg;
  localparam int unsigned REG_AW   = 4;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned DAY_BITS = 3;
  localparam int unsigned N_FIELD  = 3;
  localparam int unsigned N_SRC    = 2;
  localparam int unsigned SRC_TOD  = 0;
  localparam int unsigned SRC_WD   = 1;

  localparam logic [REG_AW-1:0] A_AL_MIN = 4'h3;
  localparam logic [REG_AW-1:0] A_AL_HR  = 4'h5;
  localparam logic [REG_AW-1:0] A_AL_DAY = 4'h7;
  localparam logic [REG_AW-1:0] A_CMD    = 4'hB;
  localparam logic [REG_AW-1:0] A_WD_LO  = 4'hC;
  localparam logic [REG_AW-1:0] A_WD_HI  = 4'hD;

  // writable part of the command register, bits 7..2
  typedef struct packed {
    logic xfer_en;
    logic route_tod_a;
    logic drive_hi;
    logic pulse_mode;
    logic wd_mask;
    logic tod_mask;
  } cmd_t;

  localparam cmd_t CMD_RST = cmd_t'(6'b110000);
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_en,
  input  logic                 acc_wr,
  input  logic [REG_AW-1:0]    acc_addr,
  input  logic [DATA_W-1:0]    acc_wdata,
  input  logic [N_SRC-1:0]     flags,
  output logic [DATA_W-1:0]    al_min,
  output logic [DATA_W-1:0]    al_hr,
  output logic [DATA_W-1:0]    al_day,
  output cmd_t                 cmd,
  output logic                 tod_clr,
  output logic                 wd_clr,
  output logic [DATA_W-1:0]    rd_data
);
  localparam int unsigned PAD_W = DATA_W - 1 - DAY_BITS;

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (acc_addr)
      A_AL_MIN: rd_mux = al_min;
      A_AL_HR:  rd_mux = al_hr;
      A_AL_DAY: rd_mux = al_day;
      A_CMD:    rd_mux = {cmd, flags[SRC_WD], flags[SRC_TOD]};
      default:  rd_mux = '0;
    endcase
  end

  assign tod_clr = acc_en && (acc_addr == A_AL_MIN || acc_addr == A_AL_HR ||
                              acc_addr == A_AL_DAY);
  assign wd_clr  = acc_en && (acc_addr == A_WD_LO || acc_addr == A_WD_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      al_min  <= '0;
      al_hr   <= '0;
      al_day  <= '0;
      cmd     <= CMD_RST;
      rd_data <= '0;
    end else begin
      if (acc_en && acc_wr) begin
        unique case (acc_addr)
          A_AL_MIN: al_min <= acc_wdata;
          A_AL_HR:  al_hr  <= acc_wdata;
          A_AL_DAY: al_day <= {acc_wdata[DATA_W-1], {PAD_W{1'b0}},
                               acc_wdata[DAY_BITS-1:0]};
          A_CMD:    cmd    <= cmd_t'(acc_wdata[DATA_W-1:2]);
          default: ;
        endcase
      end
      if (acc_en && !acc_wr) rd_data <= rd_mux;
    end
  end

  assert_day_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_wr && acc_addr == A_AL_DAY) |=> (rd_data[DATA_W-2:DAY_BITS] == '0));

  assert_flags_readonly_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_wr && acc_addr == A_CMD) |=> (rd_data[1:0] == $past(flags)));
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_irq_pkg::*;
(
  input  logic              roll,
  input  logic [DATA_W-1:0] al_min,
  input  logic [DATA_W-1:0] al_hr,
  input  logic [DATA_W-1:0] al_day,
  input  logic [DATA_W-1:0] cur_min,
  input  logic [DATA_W-1:0] cur_hr,
  input  logic [DATA_W-1:0] cur_day,
  output logic              hit
);
  logic [N_FIELD-1:0][DATA_W-1:0] al_f;
  logic [N_FIELD-1:0][DATA_W-1:0] cur_f;
  logic [N_FIELD-1:0]             ok;

  assign al_f  = {al_day, al_hr, al_min};
  assign cur_f = {cur_day, cur_hr, cur_min};

  for (genvar i = 0; i < N_FIELD; i++) begin : g_field
    // bit 7 set: field is a don't-care; otherwise value bits must agree
    assign ok[i] = al_f[i][DATA_W-1] ||
                   ({1'b0, al_f[i][DATA_W-2:0]} == cur_f[i]);
  end

  assign hit = roll && (&ok);
endmodule

// File: rtl/irq_flag_gen.sv
module irq_flag_gen #(
  parameter int unsigned PULSE_CYC = 3000
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic pulse_mode,
  output logic flag
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      cnt  <= '0;
    end else if (clr) begin
      flag <= 1'b0;
      cnt  <= '0;
    end else if (set) begin
      flag <= 1'b1;
      cnt  <= CW'(PULSE_CYC - 1);
    end else begin
      if (flag && pulse_mode && cnt == '0) flag <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !flag);

  assert_event_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (set && !clr) |=> flag);

  assert_level_holds_R12: assert property (@(posedge clk) disable iff (rst)
    (flag && !pulse_mode && !clr) |=> flag);
endmodule

// File: rtl/tod_alarm_irq.sv
module tod_alarm_irq
  import tod_irq_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 3000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [REG_AW-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] cur_min,
  input  logic [DATA_W-1:0] cur_hour,
  input  logic [DATA_W-1:0] cur_day,
  input  logic              sec_roll,
  input  logic              wd_req,
  output logic              irq_a,
  output logic              irq_b
);
  logic [DATA_W-1:0] al_min, al_hr, al_day;
  cmd_t              cmd;
  logic              tod_clr, wd_clr, hit;
  logic [N_SRC-1:0]  fset, fclr, flags, src_mask, act;

  tod_alarm_regs u_regs (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .flags(flags),
    .al_min(al_min), .al_hr(al_hr), .al_day(al_day), .cmd(cmd),
    .tod_clr(tod_clr), .wd_clr(wd_clr), .rd_data(rd_data)
  );

  tod_alarm_match u_match (
    .roll(sec_roll), .al_min(al_min), .al_hr(al_hr), .al_day(al_day),
    .cur_min(cur_min), .cur_hr(cur_hour), .cur_day(cur_day), .hit(hit)
  );

  always_comb begin
    fset[SRC_TOD]     = hit;
    fset[SRC_WD]      = wd_req;
    fclr[SRC_TOD]     = tod_clr;
    fclr[SRC_WD]      = wd_clr;
    src_mask[SRC_TOD] = cmd.tod_mask;
    src_mask[SRC_WD]  = cmd.wd_mask;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    irq_flag_gen #(.PULSE_CYC(PULSE_CYC)) u_flag (
      .clk(clk), .rst(rst), .set(fset[g]), .clr(fclr[g]),
      .pulse_mode(cmd.pulse_mode), .flag(flags[g])
    );
  end

  assign act = flags & ~src_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_a <= 1'b0;
      irq_b <= 1'b0;
    end else begin
      irq_a <= cmd.route_tod_a ? act[SRC_TOD] : act[SRC_WD];
      irq_b <= cmd.route_tod_a ? act[SRC_WD]  : act[SRC_TOD];
    end
  end

  assert_tod_masked_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd.tod_mask) && $past(cmd.wd_mask)) |-> (!irq_a && !irq_b));

  assert_route_tod_a_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(flags[SRC_TOD]) && !$past(cmd.tod_mask) && $past(cmd.route_tod_a)) |-> irq_a);

  assert_route_tod_b_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(flags[SRC_TOD]) && !$past(cmd.tod_mask) && !$past(cmd.route_tod_a)) |-> irq_b);

  assert_wd_sets_R13: assert property (@(posedge clk) disable iff (rst)
    (wd_req && !wd_clr) |=> flags[SRC_WD]);
endmodule

// File: tb/sim_tod_alarm_irq.sv
module sim_tod_alarm_irq;
  localparam int CLK_PERIOD = 10;
  localparam int P = 5;

  logic       clk = 1'b0, rst = 1'b1;
  logic       acc_en = 0, acc_wr = 0, sec_roll = 0, wd_req = 0;
  logic [3:0] acc_addr = 0;
  logic [7:0] acc_wdata = 0, cur_min = 0, cur_hour = 0, cur_day = 0;
  logic [7:0] rd_data;
  logic       irq_a, irq_b;

  tod_alarm_irq #(.PULSE_CYC(P)) u0 (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .sec_roll(sec_roll), .wd_req(wd_req), .irq_a(irq_a), .irq_b(irq_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, errors = 0;
  string phase = "R1";
  bit    done = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] m_amin, m_ahr, m_aday, m_rd;
  logic [5:0] m_cmd;
  logic       m_tdf, m_waf, m_a, m_b;
  int         m_tc, m_wc;

  function automatic bit fld_ok(logic [7:0] al, logic [7:0] cu);
    return al[7] || (al[6:0] == cu[6:0] && cu[7] == 1'b0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_amin = 0; m_ahr = 0; m_aday = 0; m_cmd = 6'b110000;
      m_tdf = 0; m_waf = 0; m_tc = 0; m_wc = 0; m_a = 0; m_b = 0; m_rd = 0;
    end else begin
      bit ta, wa, ev, ct, cw, pm;
      ta = m_tdf && !m_cmd[0];
      wa = m_waf && !m_cmd[1];
      m_a = m_cmd[4] ? ta : wa;
      m_b = m_cmd[4] ? wa : ta;
      pm = m_cmd[2];
      if (acc_en && !acc_wr) begin
        case (acc_addr)
          4'h3: m_rd = m_amin;
          4'h5: m_rd = m_ahr;
          4'h7: m_rd = m_aday;
          4'hB: m_rd = {m_cmd, m_waf, m_tdf};
          default: m_rd = 8'h00;
        endcase
      end
      ev = sec_roll && fld_ok(m_amin, cur_min) && fld_ok(m_ahr, cur_hour) &&
           fld_ok(m_aday, cur_day);
      ct = acc_en && (acc_addr == 4'h3 || acc_addr == 4'h5 || acc_addr == 4'h7);
      cw = acc_en && (acc_addr == 4'hC || acc_addr == 4'hD);
      if (ct) begin m_tdf = 0; m_tc = 0; end
      else if (ev) begin m_tdf = 1; m_tc = P - 1; end
      else begin
        if (m_tdf && pm && m_tc == 0) m_tdf = 0;
        if (m_tc > 0) m_tc--;
      end
      if (cw) begin m_waf = 0; m_wc = 0; end
      else if (wd_req) begin m_waf = 1; m_wc = P - 1; end
      else begin
        if (m_waf && pm && m_wc == 0) m_waf = 0;
        if (m_wc > 0) m_wc--;
      end
      if (acc_en && acc_wr) begin
        case (acc_addr)
          4'h3: m_amin = acc_wdata;
          4'h5: m_ahr = acc_wdata;
          4'h7: m_aday = {acc_wdata[7], 4'b0000, acc_wdata[2:0]};
          4'hB: m_cmd = acc_wdata[7:2];
          default: ;
        endcase
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(phase, {31'b0, irq_a}, {31'b0, m_a});
      chk(phase, {31'b0, irq_b}, {31'b0, m_b});
      chk(phase, {24'b0, rd_data}, {24'b0, m_rd});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk); acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
    @(negedge clk); acc_en = 1; acc_wr = 0; acc_addr = a;
    @(negedge clk); acc_en = 0;
    chk(tag, {24'b0, rd_data}, {24'b0, exp});
  endtask

  task automatic roll(logic [7:0] mi, logic [7:0] hr, logic [7:0] dy);
    @(negedge clk); cur_min = mi; cur_hour = hr; cur_day = dy; sec_roll = 1;
    @(negedge clk); sec_roll = 0;
  endtask

  task automatic pulse_wd();
    @(negedge clk); wd_req = 1;
    @(negedge clk); wd_req = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1
    phase = "R1";
    rd(4'hB, 8'hC0, "R1");
    rd(4'h3, 8'h00, "R1");
    chk("R1", {31'b0, irq_a | irq_b}, 0);
    // R2
    phase = "R2";
    wr(4'h3, 8'h45); wr(4'h5, 8'h12); wr(4'h7, 8'hFF);
    rd(4'h3, 8'h45, "R2"); rd(4'h5, 8'h12, "R2"); rd(4'h7, 8'h87, "R2");
    wr(4'h7, 8'h03);
    // R3
    phase = "R3";
    roll(8'h45, 8'h12, 8'h04);
    rd(4'hB, 8'hC0, "R3");
    roll(8'h45, 8'h12, 8'h03);
    rd(4'hB, 8'hC1, "R3");
    chk("R11", {31'b0, irq_a}, 1);
    // R8
    phase = "R8";
    rd(4'h3, 8'h45, "R8");
    idle(1);
    chk("R8", {31'b0, irq_a}, 0);
    rd(4'hB, 8'hC0, "R8");
    @(negedge clk); cur_min = 8'h45; cur_hour = 8'h12; cur_day = 8'h03;
    sec_roll = 1; acc_en = 1; acc_wr = 0; acc_addr = 4'h5;
    @(negedge clk); sec_roll = 0; acc_en = 0;
    rd(4'hB, 8'hC0, "R8");
    // R7
    phase = "R7";
    idle(3);
    rd(4'hB, 8'hC0, "R7");
    // R4
    phase = "R4";
    wr(4'h7, 8'h85);
    roll(8'h45, 8'h13, 8'h01);
    rd(4'hB, 8'hC0, "R4");
    roll(8'h45, 8'h12, 8'h01);
    rd(4'hB, 8'hC1, "R4");
    rd(4'h7, 8'h85, "R4");
    // R5
    phase = "R5";
    wr(4'h5, 8'h92);
    roll(8'h44, 8'h09, 8'h02);
    rd(4'hB, 8'hC0, "R5");
    roll(8'h45, 8'h09, 8'h02);
    rd(4'hB, 8'hC1, "R5");
    // R6
    phase = "R6";
    wr(4'h3, 8'hC5);
    roll(8'h10, 8'h01, 8'h06);
    rd(4'hB, 8'hC1, "R6");
    // R9 (flag still set)
    phase = "R9";
    wr(4'hB, 8'hC0);
    rd(4'hB, 8'hC1, "R9");
    rd(4'h3, 8'hC5, "R9");
    wr(4'hB, 8'hC3);
    rd(4'hB, 8'hC0, "R9");
    // R10
    phase = "R10";
    wr(4'hB, 8'hC4);
    roll(8'h11, 8'h01, 8'h06);
    idle(2);
    chk("R10", {31'b0, irq_a}, 0);
    rd(4'hB, 8'hC5, "R10");
    rd(4'h3, 8'hC5, "R10");
    wr(4'hB, 8'hC8);
    pulse_wd();
    idle(2);
    chk("R10", {31'b0, irq_b}, 0);
    rd(4'hB, 8'hCA, "R10");
    rd(4'hC, 8'h00, "R10");
    rd(4'hB, 8'hC8, "R10");
    // R11
    phase = "R11";
    wr(4'hB, 8'h80);
    roll(8'h12, 8'h01, 8'h06);
    idle(2);
    chk("R11", {31'b0, irq_b}, 1);
    chk("R11", {31'b0, irq_a}, 0);
    pulse_wd();
    idle(2);
    chk("R11", {31'b0, irq_a}, 1);
    wr(4'hD, 8'h00);
    rd(4'h5, 8'h92, "R11");
    idle(2);
    chk("R11", {31'b0, irq_a | irq_b}, 0);
    // R13
    phase = "R13";
    wr(4'hB, 8'hC0);
    pulse_wd();
    rd(4'hB, 8'hC2, "R13");
    chk("R13", {31'b0, irq_b}, 1);
    wr(4'hC, 8'h25);
    rd(4'hB, 8'hC0, "R13");
    // R12
    phase = "R12";
    wr(4'hB, 8'hD0);
    roll(8'h13, 8'h02, 8'h06);
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (irq_a) hi++;
    end
    chk("R12", hi, P);
    rd(4'hB, 8'hD0, "R12");
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule